// File: doc/BRIEF.md
# Four-Word-Line Direct-Mapped Cache Controller

This controller sits between a 32-bit processor bus and a slower main memory. It holds a direct-mapped cache in which every line carries four data words, one shared tag and a valid bit. Tags and data are kept in internal register arrays. The tag array has one entry per line. The data array has one entry per word, so it is four times as deep as the tag array.

A processor request is captured in one cycle and checked against the tag array in the next. The match result drives the processor ready signal directly. A read miss issues one burst read to main memory. Memory returns the requested word first and the other three words in interleaved order. Ready goes to the processor with that first word. The data array takes one word per clock, and the line's tag and valid bit are written once, when the last word arrives.

Writes go through to main memory. They also update the cached word on a hit. A write miss does not allocate a line. Sizes are parameters: the address width, the data width and the number of lines. The line length is fixed at four words.

Top module: `cache_line_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` and `mem_req` are low, and the first read of any address is a miss.
- R2: A read whose line is valid with a matching tag raises `cpu_ready` in the cycle after the request is captured, with the stored word on `cpu_rdata`. It starts no memory transaction.
- R3: A read miss raises `mem_req` with `mem_we` low in the cycle after the lookup. `mem_addr` is the requested word address. `mem_req` and `mem_addr` stay steady until the last word is accepted.
- R4: During a refill, the first `mem_ack` beat carries the requested word. `cpu_ready` is high in that same cycle, and `cpu_rdata` equals `mem_rdata`.
- R5: Refill beat k (k = 0..3) carries word offset (requested offset XOR k) and is stored at that offset. Afterwards all four words of the line hit and return the memory contents.
- R6: The refill accepts one beat on every clock when `mem_ack` is high on consecutive cycles.
- R7: The tag and valid bit of a line are written once, with the fourth beat. A later read with the same index and a different tag misses and replaces the line.
- R8: A write that hits updates the cached word and also writes to memory with `mem_we` high. `cpu_ready` rises in the cycle memory acknowledges the write.
- R9: A write that misses writes memory only. The line that was resident stays resident, and a later read of the written address misses and returns the new value from memory.
- R10: `cpu_ready` is never high on two consecutive cycles.
- R11: The address fields are: word offset = `cpu_addr[1:0]`, line index = the next log2(LINES) bits, and tag = the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_ready | output | 1 | Request complete for one cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory transaction active |
| mem_we | output | 1 | 1 = memory write, 0 = burst read |
| mem_addr | output | ADDR_W | Word address (requested word for reads) |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | One data beat or write completion this cycle |
| mem_rdata | input | DATA_W | Memory read data for the current beat |

## Verification
Some properties are checked by assertions on every cycle:
- a hit starts no memory traffic;
- a read miss raises a read request the next cycle;
- the memory address stays stable during a transaction;
- ready never lasts two cycles;
- a finished refill leaves its line valid with the new tag.

Other behaviour can only be shown by the bench's scenarios, because it depends on data returned across whole transactions:
- the critical-word-first return;
- the interleaved placement of the four beats;
- replacement of a line by a conflicting tag;
- write-through values seen after eviction;
- the absence of allocation on a write miss.

The bench sweeps every line index and every starting offset of a small configuration. It does so with memory returning beats both spaced and back to back.

// File: rtl/cache_pkg.sv
package cache_pkg;

    // Words per cache line and the offset width derived from it.
    localparam int LINE_WORDS = 4;
    localparam int OFF_W      = $clog2(LINE_WORDS);

    typedef enum logic [1:0] {
        ST_IDLE,   // waiting for a processor request
        ST_LOOK,   // tag compare cycle
        ST_FILL,   // burst refill from memory
        ST_WRITE   // write-through to memory
    } ctrl_state_e;

    // Word offset carried by a refill beat in interleaved order.
    function automatic logic [OFF_W-1:0] beat_word(
        input logic [OFF_W-1:0] first,
        input logic [OFF_W-1:0] beat
    );
        return first ^ beat;
    endfunction

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int LINES = 256,
    parameter int TAG_W = 10,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

    // A completed line write leaves that line valid with the written tag.
    assert_line_installed_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] word_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            word_q[waddr] <= wdata;
        end
    end

    assign rdata = word_q[raddr];

endmodule

// File: rtl/cache_line_ctrl.sv
module cache_line_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter int LINES  = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int DEPTH = LINES * LINE_WORDS;
    localparam int DA_W  = IDX_W + OFF_W;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } cpu_op_t;

    ctrl_state_e      state_q, state_d;
    cpu_op_t          op_q;
    logic [OFF_W-1:0] beat_q;

    logic [OFF_W-1:0]  op_off;
    logic [IDX_W-1:0]  op_idx;
    logic [TAG_W-1:0]  op_tag;
    logic              tag_hit;
    logic              in_look, fill_beat, last_beat;
    logic              d_we;
    logic [DA_W-1:0]   d_waddr;
    logic [DATA_W-1:0] d_wdata;
    logic [DATA_W-1:0] d_rdata;

    // Address split: offset low, index next, tag on top.
    assign op_off = op_q.addr[OFF_W-1:0];
    assign op_idx = op_q.addr[OFF_W +: IDX_W];
    assign op_tag = op_q.addr[ADDR_W-1 -: TAG_W];

    assign in_look   = (state_q == ST_LOOK);
    assign fill_beat = (state_q == ST_FILL) && mem_ack;
    assign last_beat = fill_beat && (beat_q == OFF_W'(LINE_WORDS - 1));

    cache_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (op_idx),
        .rd_tag (op_tag),
        .hit    (tag_hit),
        .wr_en  (last_beat),
        .wr_idx (op_idx),
        .wr_tag (op_tag)
    );

    always_comb begin
        d_we    = (in_look && tag_hit && op_q.we) || fill_beat;
        d_waddr = fill_beat ? {op_idx, beat_word(op_off, beat_q)} : {op_idx, op_off};
        d_wdata = fill_beat ? mem_rdata : op_q.wdata;
    end

    cache_data_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_data (
        .clk   (clk),
        .we    (d_we),
        .waddr (d_waddr),
        .wdata (d_wdata),
        .raddr ({op_idx, op_off}),
        .rdata (d_rdata)
    );

    // Processor side: the tag match feeds ready directly.
    always_comb begin
        cpu_ready = (in_look && tag_hit && !op_q.we)
                 || (fill_beat && beat_q == '0)
                 || (state_q == ST_WRITE && mem_ack);
        cpu_rdata = (state_q == ST_FILL) ? mem_rdata : d_rdata;
    end

    // Memory side.
    assign mem_req   = (state_q == ST_FILL) || (state_q == ST_WRITE);
    assign mem_we    = op_q.we;
    assign mem_addr  = op_q.addr;
    assign mem_wdata = op_q.wdata;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cpu_req) state_d = ST_LOOK;
            ST_LOOK: begin
                if (op_q.we)      state_d = ST_WRITE;
                else if (tag_hit) state_d = ST_IDLE;
                else              state_d = ST_FILL;
            end
            ST_FILL:  if (last_beat) state_d = ST_IDLE;
            ST_WRITE: if (mem_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_req) begin
                op_q <= '{we: cpu_we, addr: cpu_addr, wdata: cpu_wdata};
            end
            if (in_look) begin
                beat_q <= '0;
            end else if (fill_beat) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    assert_hit_no_memory_R2: assert property (@(posedge clk) disable iff (rst)
        (in_look && tag_hit && !op_q.we) |=> !mem_req);

    assert_miss_fetch_R3: assert property (@(posedge clk) disable iff (rst)
        (in_look && !tag_hit && !op_q.we) |=> (mem_req && !mem_we && mem_addr == $past(op_q.addr)));

    assert_addr_steady_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr));

    assert_ready_single_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

endmodule

// File: tb/test_cache_line_ctrl.sv
module test_cache_line_ctrl;

    localparam int AW = 10;
    localparam int DW = 32;
    localparam int NL = 16;
    localparam int FIRST_WAIT = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int mem_starts = 0;
    int gap = 1;
    int ready_runs = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cache_line_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) i_cache_line_ctrl (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [DW-1:0] init_word(input logic [AW-1:0] a);
        return (32'(a) * 32'h0100_0193) ^ 32'hC0DE_0000;
    endfunction

    function automatic logic [AW-1:0] mk(input int tag, input int idx, input int off);
        return {4'(tag), 4'(idx), 2'(off)};
    endfunction

    // ---------------- main memory model ----------------
    logic [DW-1:0] mem [1 << AW];
    int m_cnt, m_beat;
    bit m_done, prev_req;

    function automatic logic [AW-1:0] beat_addr(input int b);
        return {mem_addr[AW-1:2], mem_addr[1:0] ^ 2'(b)};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < (1 << AW); i++) mem[i] <= init_word(AW'(i));
        end
        if (rst || !mem_req) begin
            m_cnt <= 0; m_beat <= 0; m_done <= 1'b0; mem_ack <= 1'b0;
        end else if (!m_done) begin
            if (mem_ack) begin
                if (mem_we || m_beat == 3) begin
                    mem_ack <= 1'b0; m_done <= 1'b1;
                end else if (gap == 0) begin
                    mem_ack <= 1'b1; mem_rdata <= mem[beat_addr(m_beat + 1)]; m_beat <= m_beat + 1;
                end else begin
                    mem_ack <= 1'b0; m_beat <= m_beat + 1; m_cnt <= 0;
                end
            end else if (m_cnt == ((m_beat == 0) ? FIRST_WAIT - 1 : gap - 1)) begin
                mem_ack <= 1'b1;
                if (mem_we) mem[mem_addr] <= mem_wdata;
                else        mem_rdata <= mem[beat_addr(m_beat)];
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    always @(posedge clk) begin
        prev_req <= mem_req;
        if (mem_req && !prev_req) mem_starts++;
    end

    // R10 monitor: ready must not stay high two cycles.
    bit ready_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && cpu_ready && ready_prev) ready_runs++;
        ready_prev = cpu_ready;
    end

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int lat, output int starts);
        int s0;
        s0 = mem_starts;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ready && lat < 100);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        repeat (14) @(negedge clk);
        starts = mem_starts - s0;
    endtask

    // Miss then four hits on one line.
    task automatic line_sweep(input int tag, input int idx, input int first, input string mreq);
        logic [DW-1:0] rd;
        int lat, st;
        access(1'b0, mk(tag, idx, first), '0, rd, lat, st);
        check(st == 1, mreq, 32'(st), 32'd1);
        check(lat == 2 + FIRST_WAIT, "R4 latency", 32'(lat), 32'(2 + FIRST_WAIT));
        check(rd == init_word(mk(tag, idx, first)), "R4 first word", rd, init_word(mk(tag, idx, first)));
        for (int o = 0; o < 4; o++) begin
            access(1'b0, mk(tag, idx, o), '0, rd, lat, st);
            check(lat == 1 && st == 0, "R2 hit timing", 32'(lat), 32'd1);
            check(rd == init_word(mk(tag, idx, o)),
                  (gap == 0) ? "R6 back-to-back fill" : "R5 interleaved fill",
                  rd, init_word(mk(tag, idx, o)));
        end
    endtask

    initial begin
        logic [DW-1:0] rd;
        int lat, st;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(cpu_ready == 1'b0, "R1 ready low", 32'(cpu_ready), 32'd0);
        check(mem_req == 1'b0, "R1 mem_req low", 32'(mem_req), 32'd0);

        // Phase A: spaced beats, every index, first offset = idx mod 4.
        gap = 1;
        for (int i = 0; i < NL; i++) line_sweep(3, i, i % 4, "R1 cold miss");

        // Phase B: back-to-back beats, conflicting tag replaces every line.
        gap = 0;
        for (int i = 0; i < NL; i++) line_sweep(10, i, (i + 1) % 4, "R7 conflict miss");

        // R7/R11: old tag at the same index now misses.
        access(1'b0, mk(3, 0, 2), '0, rd, lat, st);
        check(st == 1, "R7 evicted line misses", 32'(st), 32'd1);
        check(rd == init_word(mk(3, 0, 2)), "R11 tag field", rd, init_word(mk(3, 0, 2)));

        // R8: write hit.
        access(1'b1, mk(10, 3, 2), 32'hDEAD_0001, rd, lat, st);
        check(st == 1 && lat == 2 + FIRST_WAIT, "R8 write-through timing", 32'(lat), 32'(2 + FIRST_WAIT));
        access(1'b0, mk(10, 3, 2), '0, rd, lat, st);
        check(lat == 1 && st == 0, "R8 line still hit", 32'(lat), 32'd1);
        check(rd == 32'hDEAD_0001, "R8 cached word updated", rd, 32'hDEAD_0001);
        access(1'b0, mk(3, 3, 2), '0, rd, lat, st);     // evict
        access(1'b0, mk(10, 3, 2), '0, rd, lat, st);    // refetch
        check(st == 1, "R8 refetch misses", 32'(st), 32'd1);
        check(rd == 32'hDEAD_0001, "R8 memory updated", rd, 32'hDEAD_0001);

        // R9: write miss does not allocate.
        access(1'b1, mk(5, 5, 1), 32'hBEEF_0002, rd, lat, st);
        check(st == 1, "R9 write reaches memory", 32'(st), 32'd1);
        access(1'b0, mk(10, 5, 1), '0, rd, lat, st);
        check(lat == 1 && st == 0, "R9 resident line kept", 32'(lat), 32'd1);
        check(rd == init_word(mk(10, 5, 1)), "R9 resident data", rd, init_word(mk(10, 5, 1)));
        access(1'b0, mk(5, 5, 1), '0, rd, lat, st);
        check(st == 1, "R9 no allocation", 32'(st), 32'd1);
        check(rd == 32'hBEEF_0002, "R9 memory value", rd, 32'hBEEF_0002);

        check(ready_runs == 0, "R10 ready single cycle", 32'(ready_runs), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule